// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Controller

This block is the bus-facing protocol engine of a byte-addressed nonvolatile memory. It runs on a fast system clock and oversamples the serial clock and data lines. From those samples it recognises start and stop conditions and shifts in the device-select byte. It answers only when the byte carries its own identity. It then takes a word address and data bytes for writes, or streams bytes out for reads. Its only drive onto the data line is an open-drain style enable: asserting it pulls the line low.

The memory array, the address counter and the write-cycle timer live outside. The controller tells them what to do with single-cycle strobes: load the counter with a word address, advance it, hand a received byte to the write engine, and start the internal write once the master closes a write with a stop. The `ADDR_W` parameter (7 to 10) sets the memory density. It decides how many of the three select bits in the device byte are compared with strap pins, and how many become upper memory-address bits instead.

Top module: `twi_mem_slave`

## Requirements
- R1: A falling data line while the clock is high is a start and a rising one is a stop. A stop always returns the block to idle with `sda_oe` low. After reset the block is idle and drives nothing.
- R2: Incoming bits are taken on clock rising edges, MSB first. `sda_oe` only changes while the synchronized clock is low.
- R3: A device byte is acknowledged (line pulled low during the ninth clock) only when its top nibble is 1010. Bit 0 selects direction: 1 is read, 0 is write.
- R4: With `ADDR_W` of 7 or 8, device-byte bits 3..1 must equal `strap[2:0]`. With 9, bits 3..2 must equal the two strap pins and bit 1 becomes address bit 8. With 10, bit 3 must equal the single strap pin and bits 2..1 become address bits 9..8.
- R5: A device byte that does not match is not acknowledged. Every later byte is ignored until the next start.
- R6: In a write, the first byte after the device byte is acknowledged and produces one `addr_load` pulse carrying the word address. Each later byte is acknowledged and produces one `wr_req` pulse with the byte on `wr_data`, together with one `addr_inc` pulse.
- R7: `wr_commit` pulses once on a stop that ends a write in which at least one data byte was received. A stop after only the word address, or a repeated start, gives no commit.
- R8: In a read, the byte on `rd_data` is shifted out MSB first, and `addr_inc` pulses once per byte. A master acknowledge brings the next byte. A master non-acknowledge releases the line and waits for a stop or start.
- R9: While `wr_busy` is high, no device byte is acknowledged.
- R10: A repeated start at any point abandons the current byte and begins a new device byte. A word-address write followed by a repeated start and a read therefore returns the byte at the newly loaded address.
- R11: A start attempt, nine clocks with the line released, then a start and a stop leave the block idle and able to serve the next transfer, even when the sequence begins in the middle of a read byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Serial clock line as seen on the bus |
| sda_in | input | 1 | Serial data line as seen on the bus |
| sda_oe | output | 1 | High pulls the data line low |
| strap | input | 3, 2 or 1 (by `ADDR_W`) | Hard-wired select pins compared with the device byte |
| wr_busy | input | 1 | Internal write cycle in progress |
| rd_data | input | 8 | Array byte at the current counter address |
| addr_load | output | 1 | Pulse: load the address counter |
| addr_val | output | ADDR_W | Word address for `addr_load` |
| addr_inc | output | 1 | Pulse: advance the address counter |
| wr_req | output | 1 | Pulse: store `wr_data` at the current address |
| wr_data | output | 8 | Received data byte |
| wr_commit | output | 1 | Pulse: start the internal write cycle |

## Verification
The bench puts two instances on one wired-AND bus. One is built with `ADDR_W = 8` and compares all three strap bits. The other is built with `ADDR_W = 10`, compares one strap bit and takes two page bits from the device byte. Because their select spaces do not overlap, a single table of device bytes covers both select modes and both miss cases. The same bus also lets the bench check that page bits reach the loaded address. The 9-bit density is not built.

// File: rtl/twi_mem_slave.sv
module twi_mem_slave #(
  parameter int ADDR_W = 8,
  localparam int NSEL = (ADDR_W <= 8) ? 3 : ((ADDR_W == 9) ? 2 : 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              sda_oe,
  input  logic [NSEL-1:0]   strap,
  input  logic              wr_busy,
  input  logic [7:0]        rd_data,
  output logic              addr_load,
  output logic [ADDR_W-1:0] addr_val,
  output logic              addr_inc,
  output logic              wr_req,
  output logic [7:0]        wr_data,
  output logic              wr_commit
);

  localparam logic [3:0] DEV_TAG = 4'b1010;

  typedef enum logic [2:0] {S_IDLE, S_DEV, S_WADDR, S_WDATA, S_RDATA} st_t;

  st_t         st;
  logic [2:0]  scl_p, sda_p;
  logic [3:0]  cnt;
  logic [7:0]  shreg;
  logic        rd_mode, mack, wrote;
  logic [ADDR_W-1:0] word_addr;

  wire scl_now = scl_p[1];
  wire scl_old = scl_p[2];
  wire sda_now = sda_p[1];
  wire sda_old = sda_p[2];

  wire rise    = scl_now & ~scl_old;
  wire fall    = ~scl_now & scl_old;
  wire start_c = scl_now & scl_old & sda_old & ~sda_now;
  wire stop_c  = scl_now & scl_old & ~sda_old & sda_now;

  wire sel_ok  = (shreg[3 -: NSEL] == strap);
  wire dev_hit = (shreg[7:4] == DEV_TAG) && sel_ok && !wr_busy;
  wire dev_take = (st == S_DEV) && fall && (cnt == 4'd8) && dev_hit;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_p <= 3'b111;
      sda_p <= 3'b111;
    end else begin
      scl_p <= {scl_p[1:0], scl_in};
      sda_p <= {sda_p[1:0], sda_in};
    end

  generate
    if (ADDR_W > 8) begin : g_pg
      logic [ADDR_W-9:0] pg;
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n)        pg <= '0;
        else if (dev_take) pg <= shreg[ADDR_W-8:1];
      assign word_addr = {pg, shreg};
    end else begin : g_nopg
      assign word_addr = shreg[ADDR_W-1:0];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st        <= S_IDLE;
      cnt       <= '0;
      shreg     <= '0;
      rd_mode   <= 1'b0;
      mack      <= 1'b0;
      wrote     <= 1'b0;
      sda_oe    <= 1'b0;
      addr_load <= 1'b0;
      addr_val  <= '0;
      addr_inc  <= 1'b0;
      wr_req    <= 1'b0;
      wr_data   <= '0;
      wr_commit <= 1'b0;
    end else begin
      addr_load <= 1'b0;
      addr_inc  <= 1'b0;
      wr_req    <= 1'b0;
      wr_commit <= 1'b0;
      if (stop_c) begin
        st     <= S_IDLE;
        sda_oe <= 1'b0;
        cnt    <= '0;
        wr_commit <= wrote;
        wrote  <= 1'b0;
      end else if (start_c) begin
        st     <= S_DEV;
        sda_oe <= 1'b0;
        cnt    <= '0;
        wrote  <= 1'b0;
      end else begin
        case (st)
          S_DEV, S_WADDR, S_WDATA: begin
            if (rise && cnt < 4'd8) begin
              shreg <= {shreg[6:0], sda_now};
              cnt   <= cnt + 4'd1;
            end else if (rise && cnt == 4'd8) begin
              cnt <= 4'd9;
            end else if (fall && cnt == 4'd8) begin
              if (st == S_DEV) begin
                if (dev_hit) begin
                  sda_oe  <= 1'b1;
                  rd_mode <= shreg[0];
                end else begin
                  st <= S_IDLE;
                end
              end else if (st == S_WADDR) begin
                sda_oe    <= 1'b1;
                addr_load <= 1'b1;
                addr_val  <= word_addr;
              end else begin
                sda_oe   <= 1'b1;
                wr_req   <= 1'b1;
                addr_inc <= 1'b1;
                wr_data  <= shreg;
                wrote    <= 1'b1;
              end
            end else if (fall && cnt == 4'd9) begin
              cnt <= '0;
              if (st == S_DEV && rd_mode) begin
                st     <= S_RDATA;
                shreg  <= rd_data;
                sda_oe <= ~rd_data[7];
              end else begin
                sda_oe <= 1'b0;
                st     <= (st == S_DEV) ? S_WADDR : S_WDATA;
              end
            end
          end
          S_RDATA: begin
            if (rise && cnt < 4'd9) begin
              if (cnt == 4'd8) begin
                mack     <= ~sda_now;
                addr_inc <= 1'b1;
              end
              cnt <= cnt + 4'd1;
            end else if (fall) begin
              if (cnt >= 4'd1 && cnt <= 4'd7) begin
                shreg  <= {shreg[6:0], 1'b0};
                sda_oe <= ~shreg[6];
              end else if (cnt == 4'd8) begin
                sda_oe <= 1'b0;
              end else if (cnt == 4'd9) begin
                cnt <= '0;
                if (mack) begin
                  shreg  <= rd_data;
                  sda_oe <= ~rd_data[7];
                end else begin
                  st     <= S_IDLE;
                  sda_oe <= 1'b0;
                end
              end
            end
          end
          default: ;
        endcase
      end
    end

  AST_OE_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> !$past(scl_now)); // R2
  AST_STOP_GOES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    stop_c |=> (st == S_IDLE && !sda_oe)); // R1
  AST_BUSY_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DEV && fall && cnt == 4'd8 && wr_busy) |=> !sda_oe); // R9
  AST_LOAD_WITH_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    addr_load |-> (sda_oe && st == S_WADDR)); // R6
  AST_COMMIT_ON_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit |-> ($past(stop_c) && st == S_IDLE)); // R7
  AST_INC_IN_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    addr_inc |-> (st == S_WDATA || st == S_RDATA)); // R8
  AST_STRB_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({addr_load, wr_req, wr_commit})); // R6

endmodule

// File: tb/tb_twi_mem_slave.sv
module tb_twi_mem_slave;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0, mscl = 1'b1, msda = 1'b1, busy8 = 1'b0, busy10 = 1'b0;
  logic oe8, ld8, inc8, wq8, cm8, oe10, ld10, inc10, wq10, cm10;
  logic [7:0] av8, wd8, wd10, rd8, rd10;
  logic [9:0] av10;
  wire bus = msda & ~oe8 & ~oe10;

  logic [7:0] mem8 [256];
  logic [7:0] mem10 [1024];
  logic [7:0] cur8;
  logic [9:0] cur10;
  int ld_cnt8, cm_cnt8, cm_cnt10;
  int checks = 0, fails = 0;

  twi_mem_slave #(.ADDR_W(8)) dut (
    .clk(clk), .rst_n(rst_n), .scl_in(mscl), .sda_in(bus), .sda_oe(oe8),
    .strap(3'b101), .wr_busy(busy8), .rd_data(rd8), .addr_load(ld8), .addr_val(av8),
    .addr_inc(inc8), .wr_req(wq8), .wr_data(wd8), .wr_commit(cm8));

  twi_mem_slave #(.ADDR_W(10)) dut_w10 (
    .clk(clk), .rst_n(rst_n), .scl_in(mscl), .sda_in(bus), .sda_oe(oe10),
    .strap(1'b0), .wr_busy(busy10), .rd_data(rd10), .addr_load(ld10), .addr_val(av10),
    .addr_inc(inc10), .wr_req(wq10), .wr_data(wd10), .wr_commit(cm10));

  function automatic logic [7:0] seed(input int i);
    return 8'(i * 37 + 11);
  endfunction

  assign rd8  = mem8[cur8];
  assign rd10 = mem10[cur10];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem8[i] <= seed(i);
      for (int i = 0; i < 1024; i++) mem10[i] <= seed(i);
      cur8 <= '0; cur10 <= '0; ld_cnt8 <= 0; cm_cnt8 <= 0; cm_cnt10 <= 0;
    end else begin
      if (ld8) cur8 <= av8; else if (inc8) cur8 <= cur8 + 8'd1;
      if (ld10) cur10 <= av10; else if (inc10) cur10 <= cur10 + 10'd1;
      if (wq8) mem8[cur8] <= wd8;
      if (wq10) mem10[cur10] <= wd10;
      if (ld8) ld_cnt8 <= ld_cnt8 + 1;
      if (cm8) cm_cnt8 <= cm_cnt8 + 1;
      if (cm10) cm_cnt10 <= cm_cnt10 + 1;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic hp; repeat (12) @(negedge clk); endtask
  task automatic bstart; msda = 1'b1; hp; mscl = 1'b1; hp; msda = 1'b0; hp; mscl = 1'b0; hp; endtask
  task automatic bstop; msda = 1'b0; hp; mscl = 1'b1; hp; msda = 1'b1; hp; endtask
  task automatic bbit(input logic b, output logic r);
    msda = b; hp; mscl = 1'b1; hp; r = bus; hp; mscl = 1'b0; hp;
  endtask
  task automatic wbyte(input logic [7:0] v, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) bbit(v[i], r);
    bbit(1'b1, r);
    ack = !r;
  endtask
  task automatic rbyte(input logic mack, output logic [7:0] v);
    logic r;
    for (int i = 7; i >= 0; i--) begin bbit(1'b1, r); v[i] = r; end
    bbit(!mack, r);
  endtask

  // {busy8, busy10, expected ack, 0, device byte}
  localparam logic [11:0] VEC [9] = '{
    {3'b001, 1'b0, 8'hAA},  // R3 R4 dut 101 hit
    {3'b000, 1'b0, 8'hA8},  // R5 wrong strap
    {3'b001, 1'b0, 8'hA2},  // R4 w10 page 01
    {3'b001, 1'b0, 8'hA6},  // R4 w10 page 11
    {3'b000, 1'b0, 8'hAE},  // R5
    {3'b000, 1'b0, 8'hBA},  // R3 bad tag
    {3'b000, 1'b0, 8'h2A},  // R3 bad tag
    {3'b100, 1'b0, 8'hAA},  // R9 busy
    {3'b010, 1'b0, 8'hA4}   // R9 busy w10
  };

  initial begin
    logic a, a2;
    logic [7:0] d;
    int c0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R1 reset oe", {oe8, oe10}, 2'b00);
    chk("R1 reset strobes", {ld8, wq8, cm8, inc8}, 4'b0);

    foreach (VEC[k]) begin
      busy8 = VEC[k][11]; busy10 = VEC[k][10];
      bstart; wbyte(VEC[k][7:0], a);
      chk($sformatf("R3 R4 R5 R9 vector %0d", k), a, VEC[k][9]);
      bstop; busy8 = 1'b0; busy10 = 1'b0;
    end
    chk("R7 no commit w/o data", cm_cnt8 + cm_cnt10, 0);

    bstart; wbyte(8'hAA, a); wbyte(8'h3C, a2);
    chk("R6 word addr ack", a2, 1'b1);
    wbyte(8'h5E, a);
    chk("R6 data ack", a, 1'b1);
    bstop; hp;
    chk("R6 addr_val", av8, 8'h3C);
    chk("R6 data stored", mem8[8'h3C], 8'h5E);
    chk("R7 commit once", cm_cnt8, 1);

    bstart; wbyte(8'hA6, a); wbyte(8'h21, a); wbyte(8'h77, a); wbyte(8'h78, a2);
    bstop; hp;
    chk("R4 page bits in addr", av10, 10'h321);
    chk("R6 w10 first byte", mem10[10'h321], 8'h77);
    chk("R6 w10 incremented", mem10[10'h322], 8'h78);
    chk("R7 w10 commit", cm_cnt10, 1);

    bstart; wbyte(8'hA6, a); wbyte(8'h21, a); bstart; wbyte(8'hA7, a);
    rbyte(1'b0, d); bstop;
    chk("R10 R8 w10 random read", d, 8'h77);

    bstart; wbyte(8'hAA, a); wbyte(8'h3C, a); bstart; wbyte(8'hAB, a);
    chk("R10 read dev ack", a, 1'b1);
    rbyte(1'b1, d); chk("R2 R8 byte0", d, 8'h5E);
    rbyte(1'b1, d); chk("R8 byte1", d, seed(8'h3D));
    rbyte(1'b0, d); chk("R8 byte2", d, seed(8'h3E));
    hp; chk("R8 released after nack", bus, 1'b1);
    bstop;
    bstart; wbyte(8'hAB, a); rbyte(1'b0, d); bstop;
    chk("R8 current address read", d, seed(8'h3F));

    c0 = cm_cnt8;
    bstart; wbyte(8'hAA, a); wbyte(8'h10, a); wbyte(8'h99, a); bstart; bstop; hp;
    chk("R7 R10 no commit after restart", cm_cnt8, c0);

    c0 = ld_cnt8;
    bstart; wbyte(8'hA8, a); wbyte(8'hAA, a); wbyte(8'h11, a2); bstop;
    chk("R5 later byte ignored", a, 1'b0);
    chk("R5 no load", ld_cnt8, c0);

    bstart; wbyte(8'hAA, a); wbyte(8'h40, a); bstart; wbyte(8'hAB, a);
    for (int i = 0; i < 3; i++) bbit(1'b1, a2);
    bstart;
    for (int i = 0; i < 9; i++) bbit(1'b1, a2);
    bstart; bstop; hp;
    chk("R11 idle released", {oe8, bus}, 2'b01);
    bstart; wbyte(8'hAA, a);
    chk("R11 ack after recovery", a, 1'b1);
    wbyte(8'h50, a); bstart; wbyte(8'hAB, a); rbyte(1'b0, d); bstop;
    chk("R11 read after recovery", d, seed(8'h50));

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule